// File: doc/BRIEF.md
# Gradient-Based Timing Phase Detector

This block estimates the relative sampling-time error between neighbouring channels of a time-interleaved converter. It works only on the digital output codes, with no analog phase detector and no reference clock. Samples arrive one per accepted cycle, each tagged with the index of the channel that produced it.

For each sample it takes the difference to the sample before it, which is a discrete slope. It multiplies that slope by the older of the two samples. The product is credited to the channel pair the two samples span. The products are summed over a long block of decimated frames, so that quantization and thermal noise average out. The detector then dumps one signed error word per pair and starts the next block from zero.

Because the estimate comes from the signal slope and not from amplitude correlation, it stays nonzero for a tone at a quarter of the aggregate sample rate. An enable input lets the surrounding calibration loop freeze the detector while the loop is locked, and wake it again when relock is needed.

Top module: `grad_phase_det`

## Requirements
- R1: For an accepted sample x[n] whose predecessor x[n-1] contributes, the contribution is (x[n] - x[n-1]) * x[n-1]. Both samples are SAMPLE_W-bit two's complement, and the product is exact at SAMPLE_W*2+1 bits, signed.
- R2: A contribution is added to pair p, where p is the channel index of the newer sample. Pair 0 therefore spans channel NUM_CH-1 followed by channel 0.
- R3: A sample contributes nothing in two cases: its predecessor is stale, or the predecessor's channel is not the one just before it (modulo NUM_CH). The first sample after reset is stale.
- R4: A frame ends on each accepted sample with channel index NUM_CH-1. A frame counter starts at 0 after reset and counts modulo DECIM. Only samples accepted while the counter is 0 contribute.
- R5: After BLOCK_LEN contributing frames, the last sample of the final frame closes the block. errValid is then high for one cycle, two rising edges after the edge that accepted that sample. Pair p's word sits at errWords[p*ERR_W +: ERR_W] and equals bits [ACC_W-1 -: ERR_W] of that pair's sum.
- R6: All pair sums restart from zero after a dump, so each word reflects only its own block.
- R7: While enable is low, samples are ignored and counters and sums hold. The outputs do not change two cycles on, and the first sample after enable returns is stale.
- R8: Between dumps errValid stays low and errWords hold their last value. A cycle with sampleValid low (enable high) changes nothing.
- R9: Reset clears errValid, all error words, all sums and both counters.
- R10: A quarter-rate tone (A, 0, -A, 0 on channels 0..3) yields nonzero words on pairs 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Detector runs when high; freezes when low |
| sampleValid | input | 1 | sampleIn and chanIdx carry a sample this cycle |
| sampleIn | input | SAMPLE_W | Converter output code, two's complement |
| chanIdx | input | log2(NUM_CH) | Channel that produced sampleIn |
| errValid | output | 1 | One-cycle strobe when new error words are out |
| errWords | output | NUM_CH*ERR_W | Signed error word per pair, pair p at bits p*ERR_W upward |

## Verification
A quarter-rate alternating tone is the pattern that defeats amplitude correlation. Here it must give exact nonzero words on the odd pairs and zero on the even pairs. Random full-scale codes on an orderly channel rotation, with random gaps in sampleValid, check the product arithmetic, the pair steering and the frame decimation. Gaps in valid must not count as frames.

Random channel skips separate adjacency gating from plain accumulation. Stretches with enable low that carry junk samples show the freeze and the stale predecessor on wake-up. Codes pinned at -2048 and 2047 exercise the sign and width of the product.

// File: rtl/gpd_pkg.sv
package gpd_pkg;

  // Per-sample strobes from the control to the datapath
  typedef struct packed {
    logic capture;   // register sampleIn as the next predecessor
    logic accum;     // this sample's product joins its pair sum
    logic dump;      // this sample closes the block
  } gpd_strb_t;

endpackage

// File: rtl/gpd_ctrl.sv
module gpd_ctrl
  import gpd_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int DECIM     = 8,
  parameter int BLOCK_LEN = 4096,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            sampleValid,
  input  logic [CH_W-1:0] chanIdx,
  output gpd_strb_t       strb
);

  localparam int DEC_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam int BLK_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;

  logic [CH_W-1:0]  prevChan;
  logic [CH_W-1:0]  expectChan;
  logic             prevOk;
  logic [DEC_W-1:0] decCnt;
  logic [BLK_W-1:0] blkCnt;
  logic             accept;
  logic             lastChan;
  logic             adjacent;
  logic             frameActive;
  logic             blockDone;

  always_comb begin
    accept      = enable && sampleValid;
    lastChan    = (chanIdx == CH_W'(NUM_CH - 1));
    expectChan  = (prevChan == CH_W'(NUM_CH - 1)) ? '0 : prevChan + CH_W'(1);
    adjacent    = prevOk && (chanIdx == expectChan);
    frameActive = (decCnt == '0);
    blockDone   = (blkCnt == BLK_W'(BLOCK_LEN - 1));

    strb.capture = accept;
    strb.accum   = accept && adjacent && frameActive;
    strb.dump    = accept && lastChan && frameActive && blockDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevChan <= '0;
      prevOk   <= 1'b0;
      decCnt   <= '0;
      blkCnt   <= '0;
    end else if (!enable) begin
      prevOk <= 1'b0;
    end else if (sampleValid) begin
      prevOk   <= 1'b1;
      prevChan <= chanIdx;
      if (lastChan) begin
        decCnt <= (decCnt == DEC_W'(DECIM - 1)) ? '0 : decCnt + DEC_W'(1);
        if (frameActive)
          blkCnt <= blockDone ? '0 : blkCnt + BLK_W'(1);
      end
    end
  end

  // R5
  dump_on_last_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dump |-> (chanIdx == CH_W'(NUM_CH - 1)));

  // R5
  blk_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkCnt <= BLK_W'(BLOCK_LEN - 1));

  // R7
  accum_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accum |-> (enable && sampleValid));

  // R3
  stale_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !strb.accum);

endmodule

// File: rtl/gpd_datapath.sv
module gpd_datapath
  import gpd_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 40,
  parameter int ERR_W    = 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  gpd_strb_t                strb,
  input  logic [SAMPLE_W-1:0]      sampleIn,
  input  logic [CH_W-1:0]          chanIdx,
  output logic                     errValid,
  output logic [NUM_CH*ERR_W-1:0]  errWords
);

  localparam int DIFF_W = SAMPLE_W + 1;
  localparam int PROD_W = DIFF_W + SAMPLE_W;

  logic signed [SAMPLE_W-1:0] prevSample;
  logic signed [SAMPLE_W-1:0] curSample;
  logic signed [DIFF_W-1:0]   diffComb;
  logic signed [PROD_W-1:0]   prodComb;
  logic signed [PROD_W-1:0]   prodQ;
  logic                       accQ;
  logic                       dumpQ;
  logic [CH_W-1:0]            pairQ;
  logic                       errValidQ;

  // Slope times the older sample
  always_comb begin
    curSample = $signed(sampleIn);
    diffComb  = DIFF_W'(curSample) - DIFF_W'(prevSample);
    prodComb  = PROD_W'(diffComb) * PROD_W'(prevSample);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= '0;
      prodQ      <= '0;
      accQ       <= 1'b0;
      dumpQ      <= 1'b0;
      pairQ      <= '0;
      errValidQ  <= 1'b0;
    end else begin
      if (strb.capture)
        prevSample <= curSample;
      prodQ     <= prodComb;
      accQ      <= strb.accum;
      dumpQ     <= strb.dump;
      pairQ     <= chanIdx;
      errValidQ <= dumpQ;
    end
  end

  assign errValid = errValidQ;

  for (genvar p = 0; p < NUM_CH; p++) begin : g_pair
    logic signed [ACC_W-1:0] accR;
    logic signed [ACC_W-1:0] sumNext;
    logic [ERR_W-1:0]        wordR;

    always_comb begin
      sumNext = accR;
      if (accQ && (pairQ == CH_W'(p)))
        sumNext = accR + ACC_W'(prodQ);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accR  <= '0;
        wordR <= '0;
      end else if (dumpQ) begin
        wordR <= sumNext[ACC_W-1 -: ERR_W];
        accR  <= '0;
      end else begin
        accR  <= sumNext;
      end
    end

    assign errWords[p*ERR_W +: ERR_W] = wordR;

    // R6
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      dumpQ |=> (accR == '0));
  end

  // R8
  words_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !errValidQ |-> $stable(errWords));

endmodule

// File: rtl/grad_phase_det.sv
module grad_phase_det
  import gpd_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int SAMPLE_W  = 12,
  parameter int ACC_W     = 40,
  parameter int ERR_W     = 16,
  parameter int BLOCK_LEN = 4096,
  parameter int DECIM     = 8,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    sampleValid,
  input  logic [SAMPLE_W-1:0]     sampleIn,
  input  logic [CH_W-1:0]         chanIdx,
  output logic                    errValid,
  output logic [NUM_CH*ERR_W-1:0] errWords
);

  gpd_strb_t strb;

  gpd_ctrl #(
    .NUM_CH   (NUM_CH),
    .DECIM    (DECIM),
    .BLOCK_LEN(BLOCK_LEN)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sampleValid(sampleValid),
    .chanIdx    (chanIdx),
    .strb       (strb)
  );

  gpd_datapath #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W),
    .ACC_W   (ACC_W),
    .ERR_W   (ERR_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .sampleIn(sampleIn),
    .chanIdx (chanIdx),
    .errValid(errValid),
    .errWords(errWords)
  );

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> ##2 (!errValid && $stable(errWords)));

endmodule

// File: tb/grad_phase_det_tb_top.sv
module grad_phase_det_tb_top;

  localparam int NCH  = 4;
  localparam int SW   = 12;
  localparam int AW   = 30;
  localparam int EW   = 20;
  localparam int BL   = 6;
  localparam int DC   = 3;
  localparam int CW   = 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               enable = 1'b0;
  logic               sampleValid = 1'b0;
  logic [SW-1:0]      sampleIn = '0;
  logic [CW-1:0]      chanIdx = '0;
  logic               errValid;
  logic [NCH*EW-1:0]  errWords;

  grad_phase_det #(
    .NUM_CH(NCH), .SAMPLE_W(SW), .ACC_W(AW), .ERR_W(EW),
    .BLOCK_LEN(BL), .DECIM(DC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleValid(sampleValid),
    .sampleIn(sampleIn), .chanIdx(chanIdx), .errValid(errValid), .errWords(errWords)
  );

  always #4ns clk = ~clk;

  typedef struct {
    longint            due;
    logic [NCH*EW-1:0] w;
  } exp_t;

  exp_t              expQ[$];
  int                checks = 0;
  int                fails = 0;
  longint            cycCnt = 0;
  bit                running = 1'b0;
  bit                finished = 1'b0;
  string             curTag = "R1";
  logic [NCH*EW-1:0] lastWords = '0;

  // Reference model state
  longint sums[NCH];
  int     prevVal = 0;
  int     prevChan = 0;
  bit     prevOk = 1'b0;
  int     decPh = 0;
  int     blk = 0;
  int     nextCh = 0;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic chk(input bit ok, input string tag, input logic [NCH*EW-1:0] act,
                     input logic [NCH*EW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [NCH*EW-1:0] packWords();
    logic [NCH*EW-1:0] w;
    for (int p = 0; p < NCH; p++) begin
      logic [AW-1:0] a;
      a = AW'(sums[p]);
      w[p*EW +: EW] = a[AW-1 -: EW];
    end
    return w;
  endfunction

  // Drive one cycle and advance the reference model from the requirements
  task automatic drive(input bit en, input bit vld, input int ch, input int val);
    @(negedge clk);
    enable      = en;
    sampleValid = vld;
    chanIdx     = CW'(ch);
    sampleIn    = SW'(val);
    if (!en) begin
      prevOk = 1'b0;                                   // R7 stale predecessor
    end else if (vld) begin
      bit adj;
      bit act;
      adj = prevOk && (ch == ((prevChan + 1) % NCH));  // R3
      act = (decPh == 0);                              // R4
      if (adj && act)
        sums[ch] += longint'(val - prevVal) * longint'(prevVal);  // R1 R2
      if (ch == NCH - 1) begin
        if (act) begin
          if (blk == BL - 1) begin                     // R5
            exp_t e;
            e.due = cycCnt + 2;
            e.w   = packWords();
            expQ.push_back(e);
            for (int p = 0; p < NCH; p++) sums[p] = 0; // R6
            blk = 0;
          end else begin
            blk++;
          end
        end
        decPh = (decPh == DC - 1) ? 0 : decPh + 1;
      end
      prevVal  = val;
      prevChan = ch;
      prevOk   = 1'b1;
    end
  endtask

  // Output monitor: strobe timing, word values, hold between dumps
  always @(negedge clk) begin
    if (running && rstN) begin
      bit due;
      due = (expQ.size() > 0) && (expQ[0].due == cycCnt);
      if (errValid || due) begin
        chk(errValid == due, {"R5 strobe ", curTag}, NCH*EW'(errValid), NCH*EW'(due));
        if (due) begin
          chk(errWords == expQ[0].w, {"R1 R2 R6 words ", curTag}, errWords, expQ[0].w);
          lastWords = expQ[0].w;
          void'(expQ.pop_front());
        end
      end else begin
        chk(errWords == lastWords, {"R8 hold ", curTag}, errWords, lastWords);
      end
    end
  end

  function automatic int rndVal();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  task automatic sendSeq(input int n, input int skipPct, input int gapPct,
                         input bit extreme);
    for (int i = 0; i < n; i++) begin
      int v;
      int ch;
      if (int'($urandom_range(99)) < gapPct) begin
        drive(1'b1, 1'b0, int'($urandom_range(NCH - 1)), rndVal());
      end else begin
        v = extreme ? (($urandom_range(1) == 0) ? -2048 : 2047) : rndVal();
        ch = nextCh;
        if (int'($urandom_range(99)) < skipPct) ch = int'($urandom_range(NCH - 1));
        drive(1'b1, 1'b1, ch, v);
        nextCh = (ch + 1) % NCH;
      end
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4321);
    for (int p = 0; p < NCH; p++) sums[p] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(errValid == 1'b0, "R9 errValid after reset", NCH*EW'(errValid), '0);
    chk(errWords == '0, "R9 words after reset", errWords, '0);
    running = 1'b1;

    // R10 quarter-rate tone on a clean channel rotation
    curTag = "R10";
    for (int i = 0; i < 3 * DC * BL * NCH; i++) begin
      int v;
      v = ((i % 4) == 0) ? 1000 : (((i % 4) == 2) ? -1000 : 0);
      drive(1'b1, 1'b1, i % NCH, v);
    end
    nextCh = 0;
    repeat (3) drive(1'b1, 1'b0, 0, 0);
    chk(lastWords[1*EW +: EW] != '0, "R10 pair1 nonzero", lastWords, '0);
    chk(lastWords[3*EW +: EW] != '0, "R10 pair3 nonzero", lastWords, '0);
    chk(lastWords[0*EW +: EW] == '0, "R10 pair0 zero", lastWords, '0);

    // R4 decimation with random valid gaps
    curTag = "R4";
    sendSeq(700, 0, 25, 1'b0);

    // R3 channel skips
    curTag = "R3";
    sendSeq(700, 12, 15, 1'b0);

    // R7 enable stretches with junk samples
    curTag = "R7";
    for (int k = 0; k < 25; k++) begin
      sendSeq(int'($urandom_range(40, 10)), 0, 10, 1'b0);
      for (int j = 0; j < int'($urandom_range(12, 3)); j++)
        drive(1'b0, $urandom_range(1) == 1, int'($urandom_range(NCH - 1)), rndVal());
    end

    // R1 full-scale codes
    curTag = "R1";
    sendSeq(400, 0, 10, 1'b1);

    // Drain outstanding dumps
    curTag = "R5";
    repeat (5) drive(1'b1, 1'b0, 0, 0);
    chk(expQ.size() == 0, "R5 all dumps delivered", NCH*EW'(expQ.size()), '0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule